// File: doc/BRIEF.md
# Turbo Interleaver Address Generator

This block produces the permuted read addresses for a duobinary turbo-code interleaver of length N couples. A single-cycle start pulse carries the length N and four permutation parameters P0, P1, P2 and P3. After that pulse the block emits one address per clock, for index j = 0 up to N-1. Each address comes with a valid flag, and the final one also carries a last flag. The addresses go to the decoder's interleaved pass, which uses them to read symbol memory in permuted order.

The permutation is P0·j + 1 plus an offset chosen by j mod 4, all taken modulo N. Odd phases add N/2 together with P1 or P3, and phase 2 adds P2. The design needs no multiplier and no divider. A running accumulator holds P0·j mod N. The four phase offsets are folded into 0..N-1 once, when the start pulse is accepted. Each output address then costs one addition and one conditional subtraction.

Top module: `turbo_ilv_addr_gen`

## Requirements
- R1: For index j the output address is (P0·j + 1) mod N when j mod 4 = 0, (P0·j + 1 + N/2 + P1) mod N when j mod 4 = 1, (P0·j + 1 + P2) mod N when j mod 4 = 2, and (P0·j + 1 + N/2 + P3) mod N when j mod 4 = 3.
- R2: A start pulse is accepted only when N is even and lies in 24..2400. Any other N leaves the block idle: no valid output and busy stays low.
- R3: A start pulse is accepted only when each of P0, P1, P2 and P3 is below N. Otherwise the block stays idle.
- R4: An accepted run produces exactly N valid addresses. Last is high together with the address of index N-1 and at no other time.
- R5: Valid is low in the cycle after an accepted start. It then stays high for N consecutive cycles, so there is one address per clock with no gaps.
- R6: Busy goes high in the cycle after an accepted start. It stays high up to and including the cycle that shows last, then falls.
- R7: N and P0..P3 are captured on the accepted start. A start pulse or a change of parameter inputs while busy is high has no effect on the running sequence.
- R8: Every valid address lies in 0..N-1.
- R9: A synchronous active-high reset clears valid, last and busy and abandons any run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled with the parameter inputs |
| len_i | input | 12 | Interleaver length N in couples |
| p0_i | input | 12 | Stride parameter P0 |
| p1_i | input | 12 | Phase-1 parameter P1 |
| p2_i | input | 12 | Phase-2 parameter P2 |
| p3_i | input | 12 | Phase-3 parameter P3 |
| addr_o | output | 12 | Permuted address P(j) |
| valid_o | output | 1 | Address is valid this cycle |
| last_o | output | 1 | Address belongs to index N-1 |
| busy_o | output | 1 | A run is in progress |

## Verification
Some properties are checked on every cycle. Addresses must stay below the captured N. Last must never appear without valid. Valid must stay continuous until last. The run must end on exactly index N-1 with the first address equal to 1. Busy must follow an accepted start and hold until last. The captured length must not move during a run. The exact four-phase values, rejection of illegal lengths and parameters, immunity to a mid-run start and recovery after reset can only be shown by the bench scenarios. Those scenarios compare each address against a multiply-and-modulo model.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int PHASES = 4;
  typedef enum logic [1:0] {PH_BASE = 2'd0, PH_HALF_A = 2'd1, PH_PLAIN = 2'd2, PH_HALF_B = 2'd3} phase_e;
endpackage

// File: rtl/ilv_param_latch.sv
module ilv_param_latch #(
  parameter int AW    = 12,
  parameter int N_MIN = 24,
  parameter int N_MAX = 2400
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic                              busy_i,
  input  logic [AW-1:0]                     len_i,
  input  logic [AW-1:0]                     p0_i,
  input  logic [AW-1:0]                     p1_i,
  input  logic [AW-1:0]                     p2_i,
  input  logic [AW-1:0]                     p3_i,
  output logic                              accept_o,
  output logic [AW-1:0]                     n_o,
  output logic [AW-1:0]                     p0_o,
  output logic [ilv_pkg::PHASES-1:0][AW-1:0] off_o
);
  localparam int EW = AW + 2;

  logic [ilv_pkg::PHASES-1:0][AW-1:0] extra;
  logic [ilv_pkg::PHASES-1:0][AW-1:0] off_nx;
  logic [EW-1:0] len_x;
  logic [EW-1:0] half_x;
  logic len_ok, par_ok;

  assign extra[ilv_pkg::PH_BASE]   = '0;
  assign extra[ilv_pkg::PH_HALF_A] = p1_i;
  assign extra[ilv_pkg::PH_PLAIN]  = p2_i;
  assign extra[ilv_pkg::PH_HALF_B] = p3_i;

  assign len_x  = {2'b00, len_i};
  assign half_x = {3'b000, len_i[AW-1:1]};

  assign len_ok = (int'(len_i) >= N_MIN) && (int'(len_i) <= N_MAX) && !len_i[0];
  assign par_ok = (p0_i < len_i) && (p1_i < len_i) && (p2_i < len_i) && (p3_i < len_i);
  assign accept_o = start_i && !busy_i && len_ok && par_ok;

  for (genvar k = 0; k < ilv_pkg::PHASES; k++) begin : g_off
    logic [EW-1:0] raw, once, twice;
    assign raw   = EW'(1) + ((k % 2 == 1) ? half_x : '0) + {2'b00, extra[k]};
    assign once  = (raw >= len_x) ? raw - len_x : raw;
    assign twice = (once >= len_x) ? once - len_x : once;
    assign off_nx[k] = twice[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_o   <= '0;
      p0_o  <= '0;
      off_o <= '0;
    end else if (accept_o) begin
      n_o   <= len_i;
      p0_o  <= p0_i;
      off_o <= off_nx;
    end
  end
endmodule

// File: rtl/ilv_step_acc.sv
module ilv_step_acc #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic [AW-1:0] n_i,
  input  logic [AW-1:0] p0_i,
  output logic          run_o,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] acc_o
);
  logic [AW:0] acc_sum;
  logic [AW:0] acc_red;
  logic        at_end;

  assign acc_sum = {1'b0, acc_o} + {1'b0, p0_i};
  assign acc_red = (acc_sum >= {1'b0, n_i}) ? acc_sum - {1'b0, n_i} : acc_sum;
  assign at_end  = (idx_o == n_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o <= 1'b0;
      idx_o <= '0;
      acc_o <= '0;
    end else if (accept_i) begin
      run_o <= 1'b1;
      idx_o <= '0;
      acc_o <= '0;
    end else if (run_o) begin
      if (at_end) run_o <= 1'b0;
      idx_o <= idx_o + 1'b1;
      acc_o <= acc_red[AW-1:0];
    end
  end
endmodule

// File: rtl/ilv_addr_out.sv
module ilv_addr_out #(
  parameter int AW = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              run_i,
  input  logic [AW-1:0]                     idx_i,
  input  logic [AW-1:0]                     acc_i,
  input  logic [AW-1:0]                     n_i,
  input  logic [ilv_pkg::PHASES-1:0][AW-1:0] off_i,
  output logic [AW-1:0]                     addr_o,
  output logic                              valid_o,
  output logic                              last_o
);
  ilv_pkg::phase_e ph;
  logic [AW:0]     sum;
  logic [AW:0]     red;

  assign ph  = ilv_pkg::phase_e'(idx_i[1:0]);
  assign sum = {1'b0, acc_i} + {1'b0, off_i[ph]};
  assign red = (sum >= {1'b0, n_i}) ? sum - {1'b0, n_i} : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= run_i;
      last_o  <= run_i && (idx_i == n_i - 1'b1);
      if (run_i) addr_o <= red[AW-1:0];
    end
  end
endmodule

// File: rtl/turbo_ilv_addr_gen.sv
module turbo_ilv_addr_gen #(
  parameter int AW    = 12,
  parameter int N_MIN = 24,
  parameter int N_MAX = 2400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] p0_i,
  input  logic [AW-1:0] p1_i,
  input  logic [AW-1:0] p2_i,
  input  logic [AW-1:0] p3_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          busy_o
);
  logic                              accept;
  logic [AW-1:0]                     n_q;
  logic [AW-1:0]                     p0_q;
  logic [ilv_pkg::PHASES-1:0][AW-1:0] off_q;
  logic                              run;
  logic [AW-1:0]                     idx;
  logic [AW-1:0]                     acc;

  ilv_param_latch #(.AW(AW), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_latch (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_i(busy_o),
    .len_i(len_i), .p0_i(p0_i), .p1_i(p1_i), .p2_i(p2_i), .p3_i(p3_i),
    .accept_o(accept), .n_o(n_q), .p0_o(p0_q), .off_o(off_q)
  );

  ilv_step_acc #(.AW(AW)) u_step (
    .clk(clk), .rst(rst), .accept_i(accept), .n_i(n_q), .p0_i(p0_q),
    .run_o(run), .idx_o(idx), .acc_o(acc)
  );

  ilv_addr_out #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .run_i(run), .idx_i(idx), .acc_i(acc),
    .n_i(n_q), .off_i(off_q),
    .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          busy_o <= 1'b0;
    else if (accept)  busy_o <= 1'b1;
    else if (last_o)  busy_o <= 1'b0;
  end
endmodule

// File: rtl/turbo_ilv_addr_gen_chk.sv
module turbo_ilv_addr_gen_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic [AW-1:0] n_q,
  input logic [AW-1:0] addr_o,
  input logic          valid_o,
  input logic          last_o,
  input logic          busy_o
);
  logic [AW:0] seen;

  always_ff @(posedge clk) begin
    if (rst)                      seen <= '0;
    else if (valid_o && last_o)   seen <= '0;
    else if (valid_o)             seen <= seen + 1'b1;
  end

  p_addr_below_n_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (addr_o < n_q));

  p_first_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_o && seen == '0) |-> (addr_o == AW'(1)));

  p_last_index_r4: assert property (@(posedge clk) disable iff (rst)
    last_o |-> (valid_o && seen == {1'b0, n_q} - 1'b1));

  p_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> valid_o);

  p_start_gap_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_o && !valid_o));

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_o) |=> busy_o);

  p_busy_covers_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> busy_o);

  p_len_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_o) |=> $stable(n_q));
endmodule

bind turbo_ilv_addr_gen turbo_ilv_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .n_q(n_q), .addr_o(addr_o),
  .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
);

// File: tb/turbo_ilv_addr_gen_bench.sv
module turbo_ilv_addr_gen_bench;
  localparam int AW = 12;
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{24, 5, 0, 0, 0},
    '{36, 11, 18, 0, 18},
    '{60, 7, 4, 32, 2},
    '{26, 25, 25, 25, 25},
    '{212, 13, 4, 2, 4},
    '{2400, 53, 62, 1200, 62}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] len_i = '0, p0_i = '0, p1_i = '0, p2_i = '0, p3_i = '0;
  logic [AW-1:0] addr_o;
  logic valid_o, last_o, busy_o;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  turbo_ilv_addr_gen u_turbo_ilv_addr_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .p0_i(p0_i), .p1_i(p1_i), .p2_i(p2_i), .p3_i(p3_i),
    .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int n, input int p0, input int p1, input int p2, input int p3, input int j);
    int base;
    base = p0 * j + 1;
    case (j % 4)
      0: return base % n;
      1: return (base + n / 2 + p1) % n;
      2: return (base + p2) % n;
      default: return (base + n / 2 + p3) % n;
    endcase
  endfunction

  task automatic pulse(input int n, input int p0, input int p1, input int p2, input int p3);
    @(negedge clk);
    start_i = 1'b1; len_i = AW'(n); p0_i = AW'(p0); p1_i = AW'(p1); p2_i = AW'(p2); p3_i = AW'(p3);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_seq(input int n, input int p0, input int p1, input int p2, input int p3, input bit disturb);
    int addr_bad = 0, last_bad = 0, val_bad = 0, first_act = 0, first_exp = 0;
    pulse(n, p0, p1, p2, p3);
    chk(busy_o && !valid_o, "R5", "gap after start (busy,valid)", {busy_o, valid_o}, 2);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (disturb && j == 3) begin
        start_i = 1'b1; len_i = 12'd24; p0_i = 12'd1; p1_i = 12'd2; p2_i = 12'd3; p3_i = 12'd4;
      end else begin
        start_i = 1'b0;
      end
      if (!valid_o) val_bad++;
      if (last_o != (j == n - 1)) last_bad++;
      if (int'(addr_o) != model(n, p0, p1, p2, p3, j) && addr_bad == 0) begin
        first_act = int'(addr_o); first_exp = model(n, p0, p1, p2, p3, j);
      end
      if (int'(addr_o) != model(n, p0, p1, p2, p3, j)) addr_bad++;
      if (j == n - 1) chk(busy_o, "R6", "busy on last", busy_o, 1);
    end
    chk(addr_bad == 0, disturb ? "R7" : "R1", "address sequence first mismatch", first_act, first_exp);
    chk(val_bad == 0, "R5", "valid gaps", val_bad, 0);
    chk(last_bad == 0, "R4", "misplaced last", last_bad, 0);
    @(negedge clk);
    chk(!valid_o && !busy_o, "R4", "after run (valid,busy)", {valid_o, busy_o}, 0);
  endtask

  task automatic try_bad(input int n, input int p0, input int p1, input int p2, input int p3, input string req);
    int seen = 0;
    pulse(n, p0, p1, p2, p3);
    if (busy_o) seen++;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (valid_o || busy_o) seen++;
    end
    chk(seen == 0, req, "illegal start left idle", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid_o && !last_o && !busy_o, "R9", "reset state", {valid_o, last_o, busy_o}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run_seq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0);

    try_bad(22, 5, 0, 0, 0, "R2");
    try_bad(2402, 5, 0, 0, 0, "R2");
    try_bad(25, 5, 0, 0, 0, "R2");
    try_bad(24, 24, 0, 0, 0, "R3");
    try_bad(24, 5, 0, 30, 0, "R3");
    try_bad(24, 5, 0, 0, 24, "R3");

    run_seq(48, 17, 10, 6, 20, 1'b1);

    pulse(60, 7, 4, 32, 2);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!valid_o && !last_o && !busy_o, "R9", "mid-run reset clears", {valid_o, last_o, busy_o}, 0);
    @(negedge clk);
    chk(!valid_o && !busy_o, "R9", "stays idle after reset", {valid_o, busy_o}, 0);
    run_seq(24, 5, 0, 0, 0, 1'b0);
    chk(addr_o < 24, "R8", "final address range", int'(addr_o), 23);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule